// File: doc/BRIEF.md
# Programmable Clock-Enable Slice

This block derives a slow, gated clock-enable strobe from one of several faster source strobes. Everything runs on a single system clock. Each source is a one-cycle enable pulse that stands in for a real source clock. A packed control word selects the source and sets two divide ratios, and the result passes through a gate before it leaves the block as a registered one-cycle strobe. Downstream logic advances once per strobe.

The block can be built in one of two variants, chosen by a parameter. The cascaded variant chains two 6-bit dividers and closes its single output through a disable bit that lives in a second register. The single-stage variant has one divider and two independent enable bits in the control word, and both enable bits gate the same divided strobe. A chip places several cascaded instances side by side to produce its family of peripheral clocks.

A simple register port reads and writes the control and gate words. Writes are synchronous and reads are combinational. A divisor change never shortens a period that is already under way. A zero divisor is accepted and behaves as a divisor of one.

Top module: `pclk_slice`

## Requirements
- R1: After reset the cascaded variant reads 0x0010_0100 at byte address 0x0 and 0x0 at byte address 0x8. The single-stage variant reads 0x0000_0103 at 0x0. Both outputs are low.
- R2: The source field sits at control bits [5:4]. Codes 0 and 1 both select src_tick_i[0], code 2 selects src_tick_i[1] and code 3 selects src_tick_i[2]. Pulses on sources that are not selected have no effect.
- R3: The first divisor sits at control bits [13:8] and is one-based. A value N emits one output strobe per N selected source pulses.
- R4: In the cascaded variant the second divisor sits at control bits [25:20]. It divides the first stage's output, so the period is N1*N2 source pulses.
- R5: A divisor field of zero behaves exactly like one, so every selected pulse passes through that stage.
- R6: A divisor written while the slice runs takes effect only after the current divided period completes.
- R7: An output strobe goes high in the cycle after the clock edge that samples the completing source pulse, and it stays high for that one cycle only.
- R8: In the cascaded variant, bit 0 at byte address 0x8 is a disable. Writing 1 holds tick_o[0] low. Writing 0 restarts the division from a count of zero.
- R9: In the single-stage variant, control bits 0 and 1 enable tick_o[0] and tick_o[1] independently from the same divided strobe. Bits [25:20] read zero and have no effect, and address 0x8 reads zero.
- R10: In the cascaded variant tick_o[1] is always low, and control bits [1:0] read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick_i | input | 3 | One-cycle source enable pulses |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register byte address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data of addr_i |
| tick_o | output | 2 | Gated divided clock-enable strobes |

## Verification
The hardest case to reach from the ports is a divisor rewrite that lands part-way through a divided period. Random stimulus only changes divisors while the slice is stopped, so a directed sequence is needed for this case. It opens the gate with a ratio of four, delivers two pulses, rewrites the ratio to two and then counts pulses until each strobe appears. A second directed sequence closes the gate part-way through a period. It then checks that a full period is needed after the gate reopens.

// File: rtl/pclk_pkg.sv
package pclk_pkg;

    localparam int DIV_W    = 6;
    localparam int SEL_W    = 2;
    localparam int REG_W    = 32;
    localparam int ADDR_W   = 4;
    localparam int SEL_LSB  = 4;
    localparam int DIV0_LSB = 8;
    localparam int DIV1_LSB = 20;
    localparam int NUM_GATE = 2;

    localparam logic [ADDR_W-1:0] CTRL_ADDR = 4'h0;
    localparam logic [ADDR_W-1:0] GATE_ADDR = 4'h8;

    typedef struct packed {
        logic [SEL_W-1:0]    sel;
        logic [DIV_W-1:0]    div0;
        logic [DIV_W-1:0]    div1;
        logic [NUM_GATE-1:0] en;
        logic                dis;
    } cfg_t;

endpackage

// File: rtl/pclk_srcsel.sv
module pclk_srcsel #(
    parameter int SEL_W = 2,
    parameter int N_SRC = (2 ** SEL_W) - 1
) (
    input  logic [N_SRC-1:0] src_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    int idx;

    // codes 0 and 1 alias the first source, code k>=1 picks source k-1
    always_comb begin
        idx    = (sel_i == '0) ? 0 : int'(sel_i) - 1;
        tick_o = 1'b0;
        for (int k = 0; k < N_SRC; k++) begin
            if (k == idx) tick_o = src_i[k];
        end
    end
endmodule

// File: rtl/pclk_div.sv
module pclk_div #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         in_tick,
    input  logic [W-1:0] div_i,
    output logic         out_tick,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] lim_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] lim;
    } st_t;

    st_t          st_d, st_q;
    logic         term;
    logic [W-1:0] lim_n;

    always_comb begin
        lim_n    = (div_i == '0) ? W'(1) : div_i;
        term     = (st_q.cnt == st_q.lim - W'(1));
        out_tick = in_tick && !clr && term;
        st_d     = st_q;
        if (clr) begin
            st_d.cnt = '0;
            st_d.lim = lim_n;
        end else if (in_tick) begin
            if (term) begin
                st_d.cnt = '0;
                st_d.lim = lim_n;   // new ratio is adopted only at terminal count
            end else begin
                st_d.cnt = st_q.cnt + W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.lim <= W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign lim_o = st_q.lim;
endmodule

// File: rtl/pclk_regs.sv
module pclk_regs
    import pclk_pkg::*;
#(
    parameter bit DUAL = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [REG_W-1:0]    wdata_i,
    output logic [REG_W-1:0]    rdata_o,
    output logic [SEL_W-1:0]    sel_o,
    output logic [DIV_W-1:0]    div0_o,
    output logic [DIV_W-1:0]    div1_o,
    output logic [NUM_GATE-1:0] gate_open_o
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            if (addr_i == CTRL_ADDR) begin
                cfg_d.sel  = wdata_i[SEL_LSB +: SEL_W];
                cfg_d.div0 = wdata_i[DIV0_LSB +: DIV_W];
                if (DUAL) cfg_d.div1 = wdata_i[DIV1_LSB +: DIV_W];
                else      cfg_d.en   = wdata_i[NUM_GATE-1:0];
            end else if (addr_i == GATE_ADDR && DUAL) begin
                cfg_d.dis = wdata_i[0];
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == CTRL_ADDR) begin
            rdata_o[SEL_LSB +: SEL_W]  = cfg_q.sel;
            rdata_o[DIV0_LSB +: DIV_W] = cfg_q.div0;
            if (DUAL) rdata_o[DIV1_LSB +: DIV_W] = cfg_q.div1;
            else      rdata_o[NUM_GATE-1:0]      = cfg_q.en;
        end else if (addr_i == GATE_ADDR && DUAL) begin
            rdata_o[0] = cfg_q.dis;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.sel  <= '0;
            cfg_q.div0 <= DIV_W'(1);
            cfg_q.div1 <= DIV_W'(1);
            cfg_q.en   <= '1;
            cfg_q.dis  <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign sel_o       = cfg_q.sel;
    assign div0_o      = cfg_q.div0;
    assign div1_o      = DUAL ? cfg_q.div1 : DIV_W'(1);
    assign gate_open_o = DUAL ? {1'b0, !cfg_q.dis} : cfg_q.en;
endmodule

// File: rtl/pclk_slice.sv
module pclk_slice
    import pclk_pkg::*;
#(
    parameter bit DUAL    = 1'b1,
    parameter int SEL_BIT = SEL_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [(2**SEL_BIT)-2:0]  src_tick_i,
    input  logic                     wr_en_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [REG_W-1:0]         wdata_i,
    output logic [REG_W-1:0]         rdata_o,
    output logic [NUM_GATE-1:0]      tick_o
);
    localparam int N_SRC = (2 ** SEL_BIT) - 1;

    typedef struct packed {
        logic [NUM_GATE-1:0] tick;
    } top_st_t;

    logic [SEL_W-1:0]    sel;
    logic [DIV_W-1:0]    div0, div1;
    logic [NUM_GATE-1:0] gate_open;
    logic                clr, sel_tick, s0_out, s1_out;
    logic [DIV_W-1:0]    s0_cnt, s0_lim, s1_cnt, s1_lim;
    top_st_t             st_d, st_q;

    pclk_regs #(.DUAL(DUAL)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .sel_o(sel), .div0_o(div0),
        .div1_o(div1), .gate_open_o(gate_open)
    );

    pclk_srcsel #(.SEL_W(SEL_W), .N_SRC(N_SRC)) u_sel (
        .src_i(src_tick_i), .sel_i(sel), .tick_o(sel_tick)
    );

    assign clr = ~|gate_open;

    pclk_div #(.W(DIV_W)) u_div0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_tick(sel_tick), .div_i(div0),
        .out_tick(s0_out), .cnt_o(s0_cnt), .lim_o(s0_lim)
    );

    generate
        if (DUAL) begin : g_cascade
            pclk_div #(.W(DIV_W)) u_div1 (
                .clk(clk), .rst_n(rst_n), .clr(clr), .in_tick(s0_out), .div_i(div1),
                .out_tick(s1_out), .cnt_o(s1_cnt), .lim_o(s1_lim)
            );
        end else begin : g_single
            assign s1_out = s0_out;
            assign s1_cnt = '0;
            assign s1_lim = DIV_W'(1);
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.tick = {NUM_GATE{s1_out}} & gate_open;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = st_q.tick;
endmodule

// File: rtl/pclk_slice_chk.sv
module pclk_slice_chk #(
    parameter int W  = 6,
    parameter int NS = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NS-1:0] src_tick,
    input logic [1:0]    tick_o,
    input logic [1:0]    gate_open,
    input logic [W-1:0]  s0_cnt,
    input logic [W-1:0]  s0_lim,
    input logic [W-1:0]  s1_cnt,
    input logic [W-1:0]  s1_lim
);
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s0_cnt < s0_lim);

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        s1_cnt < s1_lim);

    p_lim_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_lim != '0) && (s1_lim != '0));

    p_src_needed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|tick_o) |-> $past(|src_tick));

    p_gate0_shut_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_open[0] |=> !tick_o[0]);

    p_gate1_shut_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_open[1] |=> !tick_o[1]);
endmodule

bind pclk_slice pclk_slice_chk #(.W(pclk_pkg::DIV_W), .NS((2**SEL_BIT)-1)) u_chk (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick_i), .tick_o(tick_o),
    .gate_open(gate_open), .s0_cnt(s0_cnt), .s0_lim(s0_lim),
    .s1_cnt(s1_cnt), .s1_lim(s1_lim)
);

// File: tb/sim_pclk_slice.sv
module sim_pclk_slice;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  src = '0;
    logic        we0 = 1'b0, we1 = 1'b0;
    logic [3:0]  ad0 = '0, ad1 = '0;
    logic [31:0] wd0 = '0, wd1 = '0;
    logic [31:0] rd0, rd1;
    logic [1:0]  tk0, tk1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    int       cnt0, cnt1, per0, per1, sel0, sel1;
    bit       open0;
    bit [1:0] en1, exp0, exp1;

    always #2 clk = ~clk;

    pclk_slice #(.DUAL(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .src_tick_i(src), .wr_en_i(we0), .addr_i(ad0),
        .wdata_i(wd0), .rdata_o(rd0), .tick_o(tk0)
    );
    pclk_slice #(.DUAL(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .src_tick_i(src), .wr_en_i(we1), .addr_i(ad1),
        .wdata_i(wd1), .rdata_o(rd1), .tick_o(tk1)
    );

    function automatic int src_idx(int s);
        return (s == 0) ? 0 : s - 1;
    endfunction
    function automatic int eff(int d);
        return (d == 0) ? 1 : d;
    endfunction
    function automatic logic [31:0] pack0(int s, int d0, int d1);
        return (32'(d1) << 20) | (32'(d0) << 8) | (32'(s) << 4);
    endfunction
    function automatic logic [31:0] pack1(int s, int d0, int en);
        return (32'(d0) << 8) | (32'(s) << 4) | 32'(en);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(int which, logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        if (which == 0) begin we0 = 1'b1; ad0 = a; wd0 = d; end
        else            begin we1 = 1'b1; ad1 = a; wd1 = d; end
        @(negedge clk);
        we0 = 1'b0; we1 = 1'b0;
    endtask

    task automatic rd(int which, logic [3:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        if (which == 0) begin ad0 = a; #1 chk(tag, rd0, exp); end
        else            begin ad1 = a; #1 chk(tag, rd1, exp); end
    endtask

    // one cycle with a given source pattern; outputs checked one cycle later
    task automatic step(logic [2:0] s, logic [1:0] e0, logic [1:0] e1, string tag);
        @(negedge clk);
        src = s;
        @(negedge clk);
        src = '0;
        chk({tag, " u0"}, 32'(tk0), 32'(e0));
        chk({tag, " u1"}, 32'(tk1), 32'(e1));
    endtask

    task automatic run(int n, string tag);
        exp0 = '0; exp1 = '0;
        for (int c = 0; c <= n; c++) begin
            @(negedge clk);
            chk({tag, " u0"}, 32'(tk0), 32'(exp0));
            chk({tag, " u1"}, 32'(tk1), 32'(exp1));
            src = (c == n) ? 3'b000 : 3'($urandom_range(0, 7));
            exp0 = '0; exp1 = '0;
            if (open0 && src[src_idx(sel0)]) begin
                cnt0++;
                if (cnt0 % per0 == 0) exp0 = 2'b01;
            end
            if (en1 != 0 && src[src_idx(sel1)]) begin
                cnt1++;
                if (cnt1 % per1 == 0) exp1 = en1;
            end
        end
        src = '0;
    endtask

    task automatic cfg_u0(int s, int d0, int d1);
        wr(0, 4'h8, 32'h1);
        wr(0, 4'h0, pack0(s, d0, d1));
        wr(0, 4'h8, 32'h0);
    endtask
    task automatic cfg_u1(int s, int d0, int junk, int en);
        wr(1, 4'h0, pack1(s, d0, 0) | (32'(junk) << 20));
        wr(1, 4'h0, pack1(s, d0, en) | (32'(junk) << 20));
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(0, 4'h0, 32'h0010_0100, "R1 u0 ctrl");
        rd(0, 4'h8, 32'h0, "R1 u0 gate");
        rd(1, 4'h0, 32'h0000_0103, "R1 u1 ctrl");
        chk("R1 u0 tick", 32'(tk0), 32'h0);
        chk("R1 u1 tick", 32'(tk1), 32'h0);

        // R9 / R10 unimplemented fields read zero
        wr(0, 4'h0, 32'hFFFF_FFFF);
        rd(0, 4'h0, 32'h03F0_3F30, "R10 u0 ctrl bits");
        wr(1, 4'h0, 32'hFFFF_FFFF);
        rd(1, 4'h0, 32'h0000_3F33, "R9 u1 ctrl bits");
        wr(1, 4'h8, 32'hFFFF_FFFF);
        rd(1, 4'h8, 32'h0, "R9 u1 gate addr");

        // R2 source mapping, divide by one
        cfg_u0(3, 1, 1); cfg_u1(1, 1, 0, 1);
        step(3'b011, 2'b00, 2'b01, "R2 code3 ignores src0/1");
        step(3'b100, 2'b01, 2'b00, "R2 code3 takes src2");
        cfg_u0(1, 1, 1);
        step(3'b001, 2'b01, 2'b01, "R2 code1 aliases src0");

        // R5 zero divisors pass through, continuous pulses
        cfg_u0(0, 0, 0); cfg_u1(0, 0, 0, 3);
        step(3'b001, 2'b01, 2'b11, "R5 zero div a");
        step(3'b001, 2'b01, 2'b11, "R5 zero div b");

        // R4 cascade 2*3
        cfg_u0(0, 2, 3); cfg_u1(0, 1, 5, 2);
        for (int i = 1; i <= 6; i++)
            step(3'b001, (i == 6) ? 2'b01 : 2'b00, 2'b10, "R4 cascade / R9 en1 only");

        // R6 divisor change mid-period
        cfg_u0(0, 4, 1);
        step(3'b001, 2'b00, 2'b10, "R6 t1");
        step(3'b001, 2'b00, 2'b10, "R6 t2");
        wr(0, 4'h0, pack0(0, 2, 1));
        step(3'b001, 2'b00, 2'b10, "R6 t3 old ratio");
        step(3'b001, 2'b01, 2'b10, "R6 t4 old ratio ends");
        step(3'b001, 2'b00, 2'b10, "R6 t5 new ratio");
        step(3'b001, 2'b01, 2'b10, "R6 t6 new ratio");

        // R8 gate close mid-period restarts count
        cfg_u0(0, 3, 1);
        step(3'b001, 2'b00, 2'b10, "R8 pre1");
        step(3'b001, 2'b00, 2'b10, "R8 pre2");
        wr(0, 4'h8, 32'h1);
        step(3'b001, 2'b00, 2'b10, "R8 closed");
        wr(0, 4'h8, 32'h0);
        step(3'b001, 2'b00, 2'b10, "R8 reopen1");
        step(3'b001, 2'b00, 2'b10, "R8 reopen2");
        step(3'b001, 2'b01, 2'b10, "R8 reopen3");

        // random trials: R2 R3 R4 R5 R7 R9
        for (int t = 0; t < 40; t++) begin
            int d0, d1, u1d, junk;
            sel0 = $urandom_range(0, 3); d0 = $urandom_range(0, 7); d1 = $urandom_range(0, 4);
            sel1 = $urandom_range(0, 3); u1d = $urandom_range(0, 9);
            junk = $urandom_range(0, 63); en1 = 2'($urandom_range(1, 3));
            cfg_u0(sel0, d0, d1);
            cfg_u1(sel1, u1d, junk, int'(en1));
            rd(0, 4'h0, pack0(sel0, d0, d1), "R3 u0 readback");
            rd(1, 4'h0, pack1(sel1, u1d, int'(en1)), "R9 u1 readback");
            per0 = eff(d0) * eff(d1); per1 = eff(u1d);
            cnt0 = 0; cnt1 = 0; open0 = 1'b1;
            run(60, "R3 R4 R7 random");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule